// File: doc/BRIEF.md
# Pipelined No-Wait Burst SRAM

This block is a synchronous static RAM with a small internal array. Its front end is pipelined so that every clock cycle can carry a command, and reads and writes can alternate on adjacent cycles with no idle cycles between them. The address, the control lines and the write data are all captured on the rising clock edge. Write data is taken two enabled edges after its command, which is the same point at which read data leaves the block. A read-to-write change on the bus therefore costs nothing.

A command cycle either loads a new address or advances an internal 2-bit burst counter. When the counter advances, the operation from the last load carries on at the next address inside an aligned group of four words. A mode input selects the order within that group: a wrapping increment, or the start offset XOR the count. The data word has two 9-bit byte lanes, and each lane has its own write enable. A read that hits a write still held in the pipeline returns the newer data for each lane that write enables. A clock-enable input freezes the whole block.

Top module: `nowait_burst_sram`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to its idle state: dout_vld=0, dout=0, no pending operation and a zero burst count. This reset takes priority over clk_en_n.
- R2: A read command registered at enabled edge N presents the word on dout with dout_vld=1 after enabled edge N+2. After every other enabled edge, dout_vld=0 and dout=0.
- R3: A write command registered at enabled edge N stores din as sampled at enabled edge N+2. Lane 0 is din[8:0] and lane 1 is din[17:9]. A lane is written only when its lane_wr_n bit (bit 0 for lane 0) is 0.
- R4: Reads and writes can be issued on consecutive cycles in any mix. The results are exactly those of performing the commands in issue order.
- R5: When burst_ilv=0, each advance (adv_ld=1) moves to the next address as (start low 2 bits + count) mod 4.
- R6: When burst_ilv=1, each advance moves to the next address as start low 2 bits XOR count.
- R7: A load with ce1_n=0, ce2=1 and ce3_n=0 starts a read (wr_n=1) or a write (wr_n=0). Any other chip-enable combination is a deselect: nothing is written and dout_vld stays 0.
- R8: While clk_en_n=1, all inputs are ignored and all state, including dout and dout_vld, holds. Pipeline timing counts only enabled edges.
- R9: A read of an address whose write is still in the pipeline returns that write's data in the enabled lanes and the older stored data in the other lanes.
- R10: During a burst, address bits above the low two never change. The low two bits wrap within the aligned group of four.
- R11: An advance repeats the type of operation set by the last load: read, write or deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| addr | input | ADDR_W | Word address, used on a load cycle |
| adv_ld | input | 1 | 0 = load a new address and command, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read, used on a load cycle |
| lane_wr_n | input | LANES | Active-low per-lane write enables, sampled with each command |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| burst_ilv | input | 1 | Burst order: 1 = XOR order, 0 = wrapping increment |
| din | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_vld | output | 1 | dout holds read data |

## Verification
A fault in the burst counter or the stored base address shows up as a wrong read word at most two enabled edges after the faulty advance. A lost or misdirected write shows up on the first read of that address. A fault in the forwarding path shows up only when a read directly follows a write to the same address, so the stimulus places such pairs back to back, with single-lane writes among them. A fault in clock-enable handling disturbs dout during the stall itself, or shifts every later result by one or more cycles. Because the reference model compares dout and dout_vld after every edge, each of these faults is reported at the first cycle where it reaches the port.

// File: rtl/nwb_pkg.sv
// Shared types and helpers for the no-wait burst SRAM.
// Assumes: bursts span four words addressed by the low two bits.
package nwb_pkg;

    // Kind of operation travelling down the pipeline.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } nwb_op_e;

    // Low address bits for burst step 'step' from offset 'start'.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       ilv);
        return ilv ? (start ^ step) : 2'(start + step);
    endfunction

endpackage

// File: rtl/nwb_burst_ctl.sv
// Command stage: decodes a load or an advance and registers one command
// per enabled edge, with its operation, full word address and lane
// enables. Holds the burst base, the 2-bit count and the last operation.
// Assumes: ADDR_W >= 3; en is the active-high form of the clock enable.
module nwb_burst_ctl
    import nwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_ok,
    input  logic              wr_req,
    input  logic [LANES-1:0]  lane_n,
    input  logic              ilv,
    output nwb_op_e           s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_lane_n
);

    logic [ADDR_W-1:0] base_q, base_nxt;
    logic [1:0]        cnt_q, cnt_nxt;
    nwb_op_e           op_q, op_nxt;
    logic [ADDR_W-1:0] addr_nxt;

    // Next burst state: a load restarts it, an advance steps the counter.
    always_comb begin
        if (adv) begin
            base_nxt = base_q;
            cnt_nxt  = 2'(cnt_q + 2'd1);
            op_nxt   = op_q;
        end else begin
            base_nxt = addr;
            cnt_nxt  = 2'd0;
            if (!sel_ok)     op_nxt = OP_IDLE;
            else if (wr_req) op_nxt = OP_WRITE;
            else             op_nxt = OP_READ;
        end
        addr_nxt = {base_nxt[ADDR_W-1:2], burst_lo(base_nxt[1:0], cnt_nxt, ilv)};
    end

    // Register the burst state and the stage-1 command on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            cnt_q     <= 2'd0;
            op_q      <= OP_IDLE;
            s1_op     <= OP_IDLE;
            s1_addr   <= '0;
            s1_lane_n <= '1;
        end else if (en) begin
            base_q    <= base_nxt;
            cnt_q     <= cnt_nxt;
            op_q      <= op_nxt;
            s1_op     <= op_nxt;
            s1_addr   <= addr_nxt;
            s1_lane_n <= lane_n;
        end
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (cnt_q == 2'($past(cnt_q) + 2'd1))); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))); // R10
    AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (s1_op == $past(s1_op))); // R11

endmodule

// File: rtl/nwb_store.sv
// Storage array with a lane-masked write port and a registered read port.
// The write port commits the stage-2 write with the din present at this
// edge. The read port captures the stage-1 address and overlays the
// lanes written at the same edge, so reads see program order.
// Assumes: a single write per edge; no reset on the array.
module nwb_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_q
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_merged;
    logic              hit;

    assign hit = wr_go && (wr_addr == rd_addr);

    // Per-lane choice between the array word and the write landing now.
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign rd_merged[g*LANE_W +: LANE_W] = (hit && !wr_lane_n[g])
            ? din[g*LANE_W +: LANE_W]
            : mem[rd_addr][g*LANE_W +: LANE_W];
    end

    // Commit the enabled lanes of the stage-2 write.
    always_ff @(posedge clk) begin
        if (en && wr_go) begin
            for (int i = 0; i < LANES; i++) begin
                if (!wr_lane_n[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
            end
        end
    end

    // Capture the read word, forwarded where a write lands at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (en) rd_q <= rd_merged;
    end

    AST_FWD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !wr_lane_n[0]) |=> (rd_q[LANE_W-1:0] == $past(din[LANE_W-1:0]))); // R9

endmodule

// File: rtl/nowait_burst_sram.sv
// Top of the no-wait burst SRAM: decodes the chip enables and runs the
// three-stage pipeline. Stages: command register, array access, output.
// A read returns data, and a write takes its data, after the second
// enabled edge following its command.
// Assumes: clk_en_n and rst_n are synchronous to clk.
module nowait_burst_sram
    import nwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adv_ld,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    burst_ilv,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel_ok;
    nwb_op_e           s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_lane_n, s2_lane_n;
    logic [DATA_W-1:0] rd_q;

    assign en     = !clk_en_n;
    assign sel_ok = !ce1_n && ce2 && !ce3_n;

    nwb_burst_ctl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .adv       (adv_ld),
        .addr      (addr),
        .sel_ok    (sel_ok),
        .wr_req    (!wr_n),
        .lane_n    (lane_wr_n),
        .ilv       (burst_ilv),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_lane_n (s1_lane_n)
    );

    // Move the stage-1 command into the array-access stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op     <= OP_IDLE;
            s2_addr   <= '0;
            s2_lane_n <= '1;
        end else if (en) begin
            s2_op     <= s1_op;
            s2_addr   <= s1_addr;
            s2_lane_n <= s1_lane_n;
        end
    end

    nwb_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rd_addr   (s1_addr),
        .wr_go     (s2_op == OP_WRITE),
        .wr_addr   (s2_addr),
        .wr_lane_n (s2_lane_n),
        .din       (din),
        .rd_q      (rd_q)
    );

    // Output register: present the read word, or zero for any other stage-2 op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else if (en) begin
            dout_vld <= (s2_op == OP_READ);
            dout     <= (s2_op == OP_READ) ? rd_q : '0;
        end
    end

    AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_READ) |=> dout_vld); // R2
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> ($stable(dout) && $stable(dout_vld))); // R8
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv_ld && !sel_ok) |=> (s1_op == OP_IDLE)); // R7

endmodule

// File: tb/nowait_burst_sram_tb.sv
// Bench: drives scripted command streams and compares the ports after
// every clock against a behavioural model that applies commands in order.
module nowait_burst_sram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 18;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adv_ld = 1'b0;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          burst_ilv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld;

    nowait_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr),
        .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .burst_ilv(burst_ilv),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Reference model state: 0 idle, 1 read, 2 write.
    logic [DW-1:0] mm [256];
    int            m_base = 0, m_cnt = 0, m_op = 0;
    int            p_op [2] = '{0, 0};
    int            p_addr [2] = '{0, 0};
    logic [1:0]    p_lane [2] = '{2'b11, 2'b11};
    logic [DW-1:0] e_dout = '0;
    logic          e_vld = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp_v, $time);
        end
    endtask

    // Advance the model by one clock edge using the inputs held at that edge.
    task automatic model_edge();
        int a, lo;
        if (!rst_n) begin
            m_cnt = 0; m_base = 0; m_op = 0;
            p_op = '{0, 0};
            e_vld = 1'b0; e_dout = '0;
        end else if (!clk_en_n) begin
            if (p_op[1] == 2) begin
                if (!p_lane[1][0]) mm[p_addr[1]][8:0]  = din[8:0];
                if (!p_lane[1][1]) mm[p_addr[1]][17:9] = din[17:9];
            end
            if (p_op[1] == 1) begin e_vld = 1'b1; e_dout = mm[p_addr[1]]; end
            else begin e_vld = 1'b0; e_dout = '0; end
            p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_lane[1] = p_lane[0];
            if (!adv_ld) begin
                m_base = int'(addr); m_cnt = 0;
                if (!ce1_n && ce2 && !ce3_n) m_op = wr_n ? 1 : 2;
                else m_op = 0;
                a = m_base;
            end else begin
                m_cnt = (m_cnt + 1) % 4;
                lo = burst_ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
                a = (m_base / 4) * 4 + lo;
            end
            p_op[0] = m_op; p_addr[0] = a; p_lane[0] = lane_wr_n;
        end
    endtask

    // One clock: drive at the falling edge, then model and compare after the rise.
    task automatic cyc(input bit adv, input int a, input bit wn, input logic [1:0] ln,
                       input logic [2:0] ce, input logic [DW-1:0] d, input bit stall = 0);
        @(negedge clk);
        adv_ld = adv; addr = AW'(a); wr_n = wn; lane_wr_n = ln;
        {ce1_n, ce2, ce3_n} = ce; din = d; clk_en_n = stall;
        @(posedge clk);
        #1;
        model_edge();
        chk(cur_req, "dout_vld", {17'd0, dout_vld}, {17'd0, e_vld});
        chk(cur_req, "dout", dout, e_dout);
    endtask

    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] DES = 3'b110;

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 1031) ^ 18'h2A5A5);
    endfunction

    task automatic rd(input int a, input logic [DW-1:0] d = '0);
        cyc(0, a, 1, 2'b11, SEL, d);
    endtask
    task automatic wr(input int a, input logic [1:0] ln, input logic [DW-1:0] d);
        cyc(0, a, 0, ln, SEL, d);
    endtask
    task automatic idle(input logic [DW-1:0] d = '0);
        cyc(0, 0, 1, 2'b11, DES, d);
    endtask
    task automatic adv(input logic [1:0] ln, input logic [DW-1:0] d);
        cyc(1, 0, 1, ln, SEL, d);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset, asserted while clock enable is off to show reset priority.
        cur_req = "R1";
        cyc(0, 5, 0, 2'b00, SEL, '1, 1);
        cyc(0, 5, 0, 2'b00, SEL, '1, 0);
        rst_n = 1'b1;
        idle(); idle();

        // R3: fill the array with full-word writes, data two cycles behind.
        cur_req = "R3";
        for (int i = 0; i < 258; i++) begin
            if (i < 256) wr(i, 2'b00, pat(i - 2));
            else idle(pat(i - 2));
        end

        // R2: plain reads with idle gaps.
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin rd(i * 29); idle(); end
        idle(); idle();

        // R3: single-lane writes, then read back.
        cur_req = "R3";
        wr(10, 2'b10, '0); idle(); idle(18'h3FFFF);
        wr(11, 2'b01, '0); idle(); idle(18'h15555);
        rd(10); rd(11); idle(); idle();

        // R4: read and write alternating on every cycle.
        cur_req = "R4";
        wr(20, 2'b00, '0); rd(21, '0); wr(22, 2'b00, 18'h11111);
        rd(20, '0); wr(21, 2'b00, 18'h22222); rd(22, '0);
        idle(18'h33333); idle(); idle();

        // R9: read right behind a write to the same address, with mixed lanes.
        cur_req = "R9";
        wr(30, 2'b00, '0); rd(30, '0); idle(18'h0ABCD); idle(); idle();
        wr(31, 2'b01, '0); rd(31, '0); idle(18'h3F0F0); idle(); idle();
        wr(32, 2'b10, '0); wr(32, 2'b01, '0); rd(32, 18'h01234);
        idle(18'h2BEEF); idle(); idle();

        // R5: linear read burst from offset 1.
        cur_req = "R5";
        burst_ilv = 1'b0;
        rd(8'h11); adv(2'b11, '0); adv(2'b11, '0); adv(2'b11, '0); idle(); idle();

        // R6: interleaved read burst from offset 2, then offset 3.
        cur_req = "R6";
        burst_ilv = 1'b1;
        rd(8'h22); adv(2'b11, '0); adv(2'b11, '0); adv(2'b11, '0);
        rd(8'h47); adv(2'b11, '0); adv(2'b11, '0); adv(2'b11, '0); idle(); idle();

        // R10: linear write burst at the top of a group wraps inside it.
        cur_req = "R10";
        burst_ilv = 1'b0;
        wr(8'h7F, 2'b00, '0); adv(2'b00, '0); adv(2'b00, 18'h1A1A1);
        adv(2'b00, 18'h2B2B2); idle(18'h3C3C3); idle(18'h04D4D);
        rd(8'h7C); rd(8'h7D); rd(8'h7E); rd(8'h7F); rd(8'h80); idle(); idle();

        // R11: advance after a write keeps writing; after a deselect stays idle.
        cur_req = "R11";
        burst_ilv = 1'b1;
        wr(8'h90, 2'b00, '0); adv(2'b10, '0); adv(2'b00, 18'h11112);
        idle(18'h22223); idle(18'h33334); idle();
        cyc(0, 8'h94, 0, 2'b00, DES, '0); cyc(1, 0, 0, 2'b00, SEL, '0);
        cyc(1, 0, 0, 2'b00, SEL, 18'h3FFFF); idle(18'h3FFFF); idle();
        rd(8'h90); rd(8'h91); rd(8'h94); rd(8'h95); idle(); idle();

        // R7: each off chip-enable combination blocks a write.
        cur_req = "R7";
        cyc(0, 40, 0, 2'b00, 3'b110, '0); cyc(0, 41, 0, 2'b00, 3'b000, '0);
        cyc(0, 42, 0, 2'b00, 3'b011, 18'h12345); idle(18'h12345); idle(18'h12345);
        rd(40); rd(41); rd(42); idle(); idle();

        // R8: stall in the middle of reads and writes; inputs during stall ignored.
        cur_req = "R8";
        rd(50); wr(51, 2'b00, '0);
        cyc(0, 52, 0, 2'b00, SEL, 18'h3ABCD, 1);
        cyc(1, 53, 0, 2'b00, SEL, 18'h3ABCD, 1);
        cyc(0, 54, 1, 2'b00, SEL, 18'h3ABCD, 1);
        rd(52, '0); idle(18'h05A5A); idle(); idle();
        rd(51); rd(53); rd(54); idle(); idle();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule